// File: doc/BRIEF.md
# Narrow-to-Wide Bus Matching Bridge

This block sits between a FIFO with 36-bit entries and two narrow external ports, and it moves data in both directions. The narrow side runs either 18 bits per transfer (word mode) or 9 bits per transfer (byte mode). On the write path a packer gathers narrow transfers into one 36-bit word and offers it to the FIFO through a valid/ready handshake. On the read path an unpacker takes one 36-bit word from the FIFO and hands it out as a series of narrow slices.

The order in which slices fill or leave a wide word can be big-endian or little-endian. The narrow width and the byte order are both captured while reset is held, so they cannot change during traffic. Everything runs on one clock and uses a synchronous active-high reset.

Top module: `bus_match_bridge`

## Requirements
- R1: The wide side is 36 bits. In word mode a narrow transfer carries 18 bits. In byte mode it carries 9 bits: the packer uses `in_data[8:0]` and the unpacker drives `out_data[17:9]` to zero.
- R2: The packer presents one 36-bit word on `wr_valid`/`wr_data` after 2 accepted narrow transfers in word mode, or after 4 in byte mode.
- R3: In big-endian order the first narrow slice of a word occupies the most significant slice position: bits [35:18] in word mode, bits [35:27] in byte mode. Later slices fill toward bit 0. The unpacker emits slices in the same order.
- R4: In little-endian order the first narrow slice occupies bits [17:0] in word mode, or bits [8:0] in byte mode. Later slices fill upward. The unpacker emits slices in the same order.
- R5: A narrow write is taken at a rising clock edge only when both `in_en` and `in_ready` are high. Asserting `in_en` while `in_ready` is low has no effect on any later word.
- R6: `wr_valid` stays high and `wr_data` stays unchanged until `wr_ready` is seen high at a clock edge. While a completed word is waiting, the packer keeps accepting the next word's slices until only its final slice is left. At that point `in_ready` is low.
- R7: `out_ready` is high exactly when the held word still has slices that have not been read. Each edge with `out_en` and `out_ready` both high consumes one slice.
- R8: `rd_take` is high only when `rd_valid` is high and no slices remain. The word on `rd_data` is captured at that edge, and `out_ready` is high in the next cycle.
- R9: Synchronous reset clears both slice counters and discards any partial or pending word. After reset, `wr_valid`, `out_ready` and `rd_take` are low and `in_ready` is high.
- R10: `cfg_byte` (1 = byte mode) and `cfg_big` (1 = big-endian) are sampled only at edges where `rst` is high. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| rst | input | 1 | Synchronous active-high reset; also samples configuration |
| cfg_byte | input | 1 | Narrow width select sampled in reset: 1 = 9 bits, 0 = 18 bits |
| cfg_big | input | 1 | Slice order select sampled in reset: 1 = big-endian |
| in_en | input | 1 | Narrow write enable |
| in_data | input | 18 | Narrow write data |
| in_ready | output | 1 | Packer can accept a narrow write |
| wr_valid | output | 1 | Packed word is available for the FIFO |
| wr_data | output | 36 | Packed word |
| wr_ready | input | 1 | FIFO can accept a word (not full) |
| rd_valid | input | 1 | FIFO has a word on rd_data (not empty) |
| rd_data | input | 36 | Word at the FIFO head |
| rd_take | output | 1 | Pops the FIFO head at this edge |
| out_en | input | 1 | Narrow read enable |
| out_data | output | 18 | Current narrow slice |
| out_ready | output | 1 | A slice is available to read |

## Verification
The hardest state to reach is a stalled packer: a finished word is blocked by a full FIFO while the next word has filled every slice but its last. Only in that state does `in_ready` fall, and only then can an ignored enable corrupt ordering. The stimulus reaches it by alternating windows in which `wr_ready` is almost always low with windows in which it is mostly high, while `in_en` stays busy. Configuration pins are toggled every cycle outside reset, and resets are issued with a partial word in flight. Together these show that latched settings hold and that stale slices are dropped.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  typedef struct packed {
    logic byte_mode;
    logic big_end;
  } bmb_cfg_t;
endpackage

// File: rtl/bmb_cfg_latch.sv
module bmb_cfg_latch
  import bmb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_byte,
  input  logic     cfg_big,
  output bmb_cfg_t cfg
);
  // Settings are captured only while reset is held (R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.byte_mode <= cfg_byte;
      cfg.big_end   <= cfg_big;
    end
  end

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(cfg))
    else $error("configuration changed outside reset");
endmodule

// File: rtl/bmb_packer.sv
module bmb_packer #(
  parameter int WIDE_W   = 36,
  parameter int NARROW_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_mode,
  input  logic                big_end,
  input  logic                in_en,
  input  logic [NARROW_W-1:0] in_data,
  output logic                in_ready,
  output logic                wr_valid,
  output logic [WIDE_W-1:0]   wr_data,
  input  logic                wr_ready
);
  localparam int BW  = NARROW_W / 2;
  localparam int NL  = WIDE_W / BW;
  localparam int LPN = NARROW_W / BW;
  localparam int CW  = $clog2(NL);

  logic [CW-1:0]     cnt, last_idx, pos;
  logic [WIDE_W-1:0] acc, acc_nxt;
  logic              pend, take, at_last;

  assign last_idx = byte_mode ? CW'(NL - 1) : CW'(NL / LPN - 1);
  assign pos      = big_end ? (last_idx - cnt) : cnt;
  assign at_last  = (cnt == last_idx);
  // Stall only when the last slice of the next word would be needed (R6)
  assign in_ready = !(pend && at_last);
  assign take     = in_en && in_ready;
  assign wr_valid = pend;

  // One merge lane per byte position of the wide word
  for (genvar j = 0; j < NL; j++) begin : g_lane
    logic          hit;
    logic [BW-1:0] src;
    assign hit = byte_mode ? (pos == CW'(j)) : (pos == CW'(j / LPN));
    assign src = byte_mode ? in_data[BW-1:0] : in_data[(j % LPN)*BW +: BW];
    assign acc_nxt[j*BW +: BW] = (take && hit) ? src : acc[j*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      acc     <= '0;
      pend    <= 1'b0;
      wr_data <= '0;
    end else begin
      acc <= acc_nxt;
      if (take) cnt <= at_last ? '0 : cnt + 1'b1;
      if (take && at_last) begin
        pend    <= 1'b1;
        wr_data <= acc_nxt;
      end else if (pend && wr_ready) begin
        pend <= 1'b0;
      end
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)))
    else $error("pending word dropped or changed");

  p_no_take_r5: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (cnt == $past(cnt)))
    else $error("slice counter moved while stalled");

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx)
    else $error("packer counter out of range");
endmodule

// File: rtl/bmb_unpacker.sv
module bmb_unpacker #(
  parameter int WIDE_W   = 36,
  parameter int NARROW_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_mode,
  input  logic                big_end,
  input  logic                rd_valid,
  input  logic [WIDE_W-1:0]   rd_data,
  output logic                rd_take,
  input  logic                out_en,
  output logic [NARROW_W-1:0] out_data,
  output logic                out_ready
);
  localparam int BW  = NARROW_W / 2;
  localparam int NL  = WIDE_W / BW;
  localparam int LPN = NARROW_W / BW;
  localparam int CW  = $clog2(NL);

  logic [CW-1:0]     cnt, last_idx, pos;
  logic [WIDE_W-1:0] hold;
  logic              have, take, at_last;

  assign last_idx  = byte_mode ? CW'(NL - 1) : CW'(NL / LPN - 1);
  assign pos       = big_end ? (last_idx - cnt) : cnt;
  assign at_last   = (cnt == last_idx);
  assign out_ready = have;
  assign take      = out_en && have;
  // Fetch only once every slice of the held word is gone (R8)
  assign rd_take   = rd_valid && !have;

  always_comb begin
    if (byte_mode) out_data = NARROW_W'(hold[int'(pos)*BW +: BW]);
    else           out_data = hold[int'(pos)*NARROW_W +: NARROW_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
      have <= 1'b0;
      cnt  <= '0;
    end else if (rd_take) begin
      hold <= rd_data;
      have <= 1'b1;
      cnt  <= '0;
    end else if (take) begin
      if (at_last) begin
        have <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_fetch_r8: assert property (@(posedge clk) disable iff (rst)
    rd_take |-> (rd_valid && !out_ready))
    else $error("fetch while slices remain");

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> out_ready)
    else $error("fetched word not presented");

  p_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (take && at_last) |=> !out_ready)
    else $error("ready after last slice");
endmodule

// File: rtl/bus_match_bridge.sv
module bus_match_bridge
  import bmb_pkg::*;
#(
  parameter int WIDE_W   = 36,
  parameter int NARROW_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_byte,
  input  logic                cfg_big,
  input  logic                in_en,
  input  logic [NARROW_W-1:0] in_data,
  output logic                in_ready,
  output logic                wr_valid,
  output logic [WIDE_W-1:0]   wr_data,
  input  logic                wr_ready,
  input  logic                rd_valid,
  input  logic [WIDE_W-1:0]   rd_data,
  output logic                rd_take,
  input  logic                out_en,
  output logic [NARROW_W-1:0] out_data,
  output logic                out_ready
);
  bmb_cfg_t cfg;

  bmb_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .cfg_byte(cfg_byte), .cfg_big(cfg_big), .cfg(cfg)
  );

  bmb_packer #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pack (
    .clk(clk), .rst(rst), .byte_mode(cfg.byte_mode), .big_end(cfg.big_end),
    .in_en(in_en), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  bmb_unpacker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_unpack (
    .clk(clk), .rst(rst), .byte_mode(cfg.byte_mode), .big_end(cfg.big_end),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_take(rd_take),
    .out_en(out_en), .out_data(out_data), .out_ready(out_ready)
  );

  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!wr_valid && !out_ready && in_ready))
    else $error("outputs not cleared by reset");
endmodule

// File: tb/bus_match_bridge_bench.sv
module bus_match_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_byte = 1'b0, cfg_big = 1'b0;
  logic        in_en = 1'b0, wr_ready = 1'b0, rd_valid = 1'b0, out_en = 1'b0;
  logic [17:0] in_data = '0;
  logic [35:0] rd_data = '0;
  logic        in_ready, wr_valid, rd_take, out_ready;
  logic [35:0] wr_data;
  logic [17:0] out_data;

  int nchk = 0, nbad = 0;
  bit m_byt, m_big, done = 0;
  logic [35:0] wq[$];
  logic [17:0] sq[$];
  logic [3:0][17:0] part;
  int pcnt;

  always #4 clk = ~clk;

  bus_match_bridge u_bus_match_bridge (
    .clk(clk), .rst(rst), .cfg_byte(cfg_byte), .cfg_big(cfg_big),
    .in_en(in_en), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_take(rd_take),
    .out_en(out_en), .out_data(out_data), .out_ready(out_ready)
  );

  function automatic int f_n(bit byt);
    return byt ? 4 : 2;
  endfunction

  function automatic logic [35:0] f_pack(logic [3:0][17:0] s, bit byt, bit big);
    int w = byt ? 9 : 18;
    logic [35:0] r = '0;
    for (int k = 0; k < f_n(byt); k++) begin
      logic [35:0] v = byt ? {27'd0, s[k][8:0]} : {18'd0, s[k]};
      if (big) r = (r << w) | v;
      else     r = r | (v << (w * k));
    end
    return r;
  endfunction

  function automatic logic [17:0] f_slice(logic [35:0] wd, int k, bit byt, bit big);
    int w = byt ? 9 : 18;
    int idx = big ? (f_n(byt) - 1 - k) : k;
    logic [35:0] sh = wd >> (w * idx);
    return byt ? {9'd0, sh[8:0]} : sh[17:0];
  endfunction

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(bit byt, bit big);
    @(negedge clk);
    rst = 1'b1; cfg_byte = byt; cfg_big = big;
    in_en = 0; rd_valid = 0; out_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_byt = byt; m_big = big;
    wq.delete(); sq.delete(); pcnt = 0;
    #1;
    // R9: reset state
    check(in_ready == 1'b1, "R9 in_ready", 36'(in_ready), 36'd1);
    check(wr_valid == 1'b0, "R9 wr_valid", 36'(wr_valid), 36'd0);
    check(out_ready == 1'b0, "R9 out_ready", 36'(out_ready), 36'd0);
    check(rd_take == 1'b0, "R9 rd_take", 36'(rd_take), 36'd0);
  endtask

  task automatic step(int ready_pct);
    @(negedge clk);
    in_en    = ($urandom % 100) < 70;
    in_data  = 18'($urandom);
    wr_ready = ($urandom % 100) < ready_pct;
    rd_valid = ($urandom % 100) < 60;
    rd_data  = {4'($urandom), 32'($urandom)};
    out_en   = ($urandom % 100) < 65;
    cfg_byte = 1'($urandom);  // R10: must be ignored outside reset
    cfg_big  = 1'($urandom);
    #1;
    // packer side
    check(wr_valid == (wq.size() != 0), "R6 wr_valid hold", 36'(wr_valid), 36'(wq.size() != 0));
    check(in_ready == !(wq.size() != 0 && pcnt == f_n(m_byt) - 1), "R6 in_ready stall",
          36'(in_ready), 36'(!(wq.size() != 0 && pcnt == f_n(m_byt) - 1)));
    if (wr_valid && wr_ready && wq.size() != 0) begin
      logic [35:0] e = wq.pop_front();
      check(wr_data == e, m_big ? "R2/R3/R5/R10 packed word" : "R2/R4/R5/R10 packed word",
            wr_data, e);
    end
    if (in_en && in_ready) begin
      part[pcnt] = in_data;
      pcnt++;
      if (pcnt == f_n(m_byt)) begin
        wq.push_back(f_pack(part, m_byt, m_big));
        pcnt = 0;
      end
    end
    // unpacker side
    check(out_ready == (sq.size() != 0), "R7 out_ready", 36'(out_ready), 36'(sq.size() != 0));
    check(rd_take == (rd_valid && sq.size() == 0), "R8 rd_take", 36'(rd_take),
          36'(rd_valid && sq.size() == 0));
    if (out_en && out_ready && sq.size() != 0) begin
      logic [17:0] e = sq.pop_front();
      check(out_data == e, m_big ? "R1/R3/R7 slice" : "R1/R4/R7 slice", 36'(out_data), 36'(e));
    end
    if (rd_take)
      for (int k = 0; k < f_n(m_byt); k++) sq.push_back(f_slice(rd_data, k, m_byt, m_big));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(ph[1], ph[0]);
      for (int c = 0; c < 900; c++) step(((c / 60) % 2 == 0) ? 8 : 75);
      // R9: reset with a partial word in flight must discard it
      do_reset(ph[1], ph[0]);
      for (int c = 0; c < 500; c++) step(((c / 40) % 2 == 0) ? 5 : 90);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule